// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a small processor core. It holds sixteen visible general registers of `DATA_W` bits, a live saved-status word, and a set of shadow copies that belong to privilege modes. Two combinational read ports, one write port and a status read/write port serve the execution pipeline. A 5-bit mode input with a one-cycle change strobe tells the block which privilege mode the core enters.

Each mode maps to one of six shadow banks. These are a shared "plain" bank, fast-interrupt, interrupt, supervisor, abort and undefined. When a mode change crosses from one bank to another, the whole exchange finishes on one clock edge. The live stack pointer (r13), link register (r14) and saved-status word go into the slots of the bank being left, and the entering bank's slots are loaded into the live registers. Registers r8 to r12 take part in the exchange only when the fast-interrupt bank is entered or left. All other modes share one stored copy of them.

Instruction decode, the ALU, exception vectoring and the current-status flags belong to neighbouring logic.

Top module: `mode_bank_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, all sixteen registers, every shadow slot, every banked status word and the live status word become zero, and `mode_cur` becomes system mode (5'b11111).
- R2: A write (`wr_en`, `wr_idx`, `wr_data`) with no bank exchange in the same cycle is visible on both read ports from the next cycle. Any of r0 to r15 may be written. The read ports are combinational on the current contents.
- R3: The mode codes map to banks as follows. User 5'b10000 and system 5'b11111 map to the plain bank. 5'b10001 is fast-interrupt, 5'b10010 is interrupt, 5'b10011 is supervisor, 5'b10111 is abort and 5'b11011 is undefined. Every other code maps to the plain bank.
- R4: A change strobe whose requested mode equals the current mode does nothing. A change whose modes differ but share a bank updates only `mode_cur` and moves no register or status contents.
- R5: On a bank change, live r13 and r14 are saved into the old bank and replaced by the new bank's saved copies in the same edge.
- R6: On a bank change, the live status word is saved into the old bank and replaced by the new bank's saved word. Outside a bank change, `sts_wr_en` loads `sts_wr_data` into the live status word, and `sts_rd_data` always shows it.
- R7: r8 to r12 are exchanged only when the old or the new bank is fast-interrupt. The fast-interrupt bank has its own copy, and all other banks share a single copy.
- R8: A register or status write that falls in the same cycle as a bank change applies to the old mode's register before the exchange. The written value therefore lands in the old bank's slot.
- R9: `mode_cur` takes the requested code (including unrecognised codes) on a change strobe and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Register index for read port A |
| rd_a_data | output | DATA_W | Read port A data (combinational) |
| rd_b_idx | input | 4 | Register index for read port B |
| rd_b_data | output | DATA_W | Read port B data (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | DATA_W | Register write data |
| sts_wr_en | input | 1 | Live saved-status write enable |
| sts_wr_data | input | DATA_W | Live saved-status write data |
| sts_rd_data | output | DATA_W | Live saved-status word |
| mode_in | input | 5 | Requested privilege mode code |
| mode_chg | input | 1 | Mode change strobe |
| mode_cur | output | 5 | Current stored mode code |

## Verification
The collision that matters is a register or status write landing on the same edge as a bank-changing mode strobe. The written register is then both a write target and a swap source. The bench provokes this with directed cycles that write r13, r9 and the status word while entering and leaving fast-interrupt mode. Random sequences also mix writes into mode changes freely. A reference model in the bench applies the write first and then exchanges banks. It judges the outcome by reading every register back after each edge, and by returning to the old mode later to confirm that the written value was parked in the old bank's slot.

// File: rtl/mbr_pkg.sv
`timescale 1ns/1ps
package mbr_pkg;

  localparam int MODE_W    = 5;
  localparam int NUM_BANKS = 6;
  localparam int HI_LO     = 8;   // first register of the fast-interrupt-only group
  localparam int HI_N      = 5;   // r8..r12
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_PLAIN = 3'd0,
    BK_FIQ   = 3'd1,
    BK_IRQ   = 3'd2,
    BK_SVC   = 3'd3,
    BK_ABT   = 3'd4,
    BK_UND   = 3'd5
  } bank_t;

  function automatic bank_t bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_PLAIN;
    endcase
  endfunction

endpackage

// File: rtl/mbr_bank_map.sv
`timescale 1ns/1ps
module mbr_bank_map
  import mbr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_t             bank,
  output logic              is_fiq
);

  always_comb begin
    bank   = bank_of(mode);
    is_fiq = (bank == BK_FIQ);
  end

endmodule

// File: rtl/mbr_live_file.sv
`timescale 1ns/1ps
module mbr_live_file #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  parameter int SP_I   = 13,
  parameter int LR_I   = 14,
  parameter int HI_L   = 8,
  parameter int HI_C   = 5,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             ld_splr,
  input  logic [DATA_W-1:0]                ld_sp,
  input  logic [DATA_W-1:0]                ld_lr,
  input  logic                             ld_hi,
  input  logic [HI_C-1:0][DATA_W-1:0]      ld_hi_data,
  output logic [NREGS-1:0][DATA_W-1:0]     q,
  output logic [NREGS-1:0][DATA_W-1:0]     eff
);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic              hit;
    logic              load;
    logic [DATA_W-1:0] load_val;

    assign hit = wr_en && (wr_idx == IDX_W'(i));

    if (i == SP_I) begin : g_sp
      assign load     = ld_splr;
      assign load_val = ld_sp;
    end else if (i == LR_I) begin : g_lr
      assign load     = ld_splr;
      assign load_val = ld_lr;
    end else if (i >= HI_L && i < HI_L + HI_C) begin : g_hi
      assign load     = ld_hi;
      assign load_val = ld_hi_data[i-HI_L];
    end else begin : g_plain
      assign load     = 1'b0;
      assign load_val = '0;
    end

    // value after this cycle's write, before any bank exchange
    assign eff[i] = hit ? wr_data : q[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= '0;
      end else if (load) begin
        q[i] <= load_val;
      end else if (hit) begin
        q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/mbr_shadow_store.sv
`timescale 1ns/1ps
module mbr_shadow_store #(
  parameter int DATA_W = 32,
  parameter int NBANKS = 6,
  parameter int HI_C   = 5,
  localparam int BK_W  = $clog2(NBANKS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        swap,
  input  logic [BK_W-1:0]             old_bk,
  input  logic [BK_W-1:0]             new_bk,
  input  logic [DATA_W-1:0]           sp_in,
  input  logic [DATA_W-1:0]           lr_in,
  input  logic [DATA_W-1:0]           ps_in,
  output logic [DATA_W-1:0]           sp_out,
  output logic [DATA_W-1:0]           lr_out,
  output logic [DATA_W-1:0]           ps_out,
  input  logic                        hi_swap,
  input  logic                        hi_old_sel,
  input  logic                        hi_new_sel,
  input  logic [HI_C-1:0][DATA_W-1:0] hi_in,
  output logic [HI_C-1:0][DATA_W-1:0] hi_out
);

  logic [DATA_W-1:0] sp_mem [NBANKS];
  logic [DATA_W-1:0] lr_mem [NBANKS];
  logic [DATA_W-1:0] ps_mem [NBANKS];
  logic [HI_C-1:0][DATA_W-1:0] hi_mem [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANKS; b++) begin
        sp_mem[b] <= '0;
        lr_mem[b] <= '0;
        ps_mem[b] <= '0;
      end
      hi_mem[0] <= '0;
      hi_mem[1] <= '0;
    end else begin
      if (swap) begin
        sp_mem[old_bk] <= sp_in;
        lr_mem[old_bk] <= lr_in;
        ps_mem[old_bk] <= ps_in;
      end
      if (hi_swap) begin
        hi_mem[hi_old_sel] <= hi_in;
      end
    end
  end

  assign sp_out = sp_mem[new_bk];
  assign lr_out = lr_mem[new_bk];
  assign ps_out = ps_mem[new_bk];
  assign hi_out = hi_mem[hi_new_sel];

endmodule

// File: rtl/mbr_read_mux.sv
`timescale 1ns/1ps
module mbr_read_mux #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][DATA_W-1:0] regs,
  input  logic [IDX_W-1:0]             idx,
  output logic [DATA_W-1:0]            data
);

  assign data = regs[idx];

endmodule

// File: rtl/mode_bank_regfile.sv
`timescale 1ns/1ps
module mode_bank_regfile
  import mbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sts_wr_en,
  input  logic [DATA_W-1:0] sts_wr_data,
  output logic [DATA_W-1:0] sts_rd_data,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              mode_chg,
  output logic [MODE_W-1:0] mode_cur
);

  localparam int BK_W = $clog2(NUM_BANKS);

  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] spsr_q;
  logic [DATA_W-1:0] spsr_eff;

  bank_t bank_cur, bank_req;
  logic  fiq_cur, fiq_req;
  logic  chg_act, bank_swap, hi_swap;

  logic [NREGS-1:0][DATA_W-1:0] live_q, live_eff;
  logic [HI_N-1:0][DATA_W-1:0]  hi_to_shadow, hi_from_shadow;
  logic [DATA_W-1:0]            sp_new, lr_new, ps_new;

  mbr_bank_map u_map_cur (.mode(mode_q),  .bank(bank_cur), .is_fiq(fiq_cur));
  mbr_bank_map u_map_req (.mode(mode_in), .bank(bank_req), .is_fiq(fiq_req));

  assign chg_act   = mode_chg && (mode_in != mode_q);
  assign bank_swap = chg_act && (bank_cur != bank_req);
  assign hi_swap   = bank_swap && (fiq_cur || fiq_req);
  assign spsr_eff  = sts_wr_en ? sts_wr_data : spsr_q;

  for (genvar k = 0; k < HI_N; k++) begin : g_hi_route
    assign hi_to_shadow[k] = live_eff[HI_LO+k];
  end

  mbr_live_file #(
    .DATA_W(DATA_W), .NREGS(NREGS), .SP_I(SP_IDX), .LR_I(LR_IDX),
    .HI_L(HI_LO), .HI_C(HI_N)
  ) u_live (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .ld_splr    (bank_swap),
    .ld_sp      (sp_new),
    .ld_lr      (lr_new),
    .ld_hi      (hi_swap),
    .ld_hi_data (hi_from_shadow),
    .q          (live_q),
    .eff        (live_eff)
  );

  mbr_shadow_store #(
    .DATA_W(DATA_W), .NBANKS(NUM_BANKS), .HI_C(HI_N)
  ) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .swap       (bank_swap),
    .old_bk     (BK_W'(bank_cur)),
    .new_bk     (BK_W'(bank_req)),
    .sp_in      (live_eff[SP_IDX]),
    .lr_in      (live_eff[LR_IDX]),
    .ps_in      (spsr_eff),
    .sp_out     (sp_new),
    .lr_out     (lr_new),
    .ps_out     (ps_new),
    .hi_swap    (hi_swap),
    .hi_old_sel (fiq_cur),
    .hi_new_sel (fiq_req),
    .hi_in      (hi_to_shadow),
    .hi_out     (hi_from_shadow)
  );

  mbr_read_mux #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rd_a (
    .regs(live_q), .idx(rd_a_idx), .data(rd_a_data)
  );
  mbr_read_mux #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rd_b (
    .regs(live_q), .idx(rd_b_idx), .data(rd_b_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SYS;
      spsr_q <= '0;
    end else begin
      if (chg_act) mode_q <= mode_in;
      if (bank_swap) begin
        spsr_q <= ps_new;
      end else if (sts_wr_en) begin
        spsr_q <= sts_wr_data;
      end
    end
  end

  assign mode_cur    = mode_q;
  assign sts_rd_data = spsr_q;

endmodule

// File: rtl/mbr_checker.sv
`timescale 1ns/1ps
module mbr_checker
  import mbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              sts_wr_en,
  input logic [DATA_W-1:0] sts_rd_data,
  input logic [MODE_W-1:0] mode_in,
  input logic              mode_chg,
  input logic [MODE_W-1:0] mode_cur
);

  logic req_fiq, cur_fiq, rd_in_hi;
  assign req_fiq  = (bank_of(mode_in) == BK_FIQ);
  assign cur_fiq  = (bank_of(mode_cur) == BK_FIQ);
  assign rd_in_hi = (rd_a_idx >= IDX_W'(HI_LO)) && (rd_a_idx < IDX_W'(HI_LO + HI_N));

  // R1: reset leaves system mode and a cleared status word
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mode_cur == MODE_SYS && sts_rd_data == '0));

  // R9: strobe loads the requested code
  a_r9_mode_follows: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (mode_cur == $past(mode_in)));

  // R9: without a strobe the mode holds
  a_r9_mode_holds: assert property (@(posedge clk) disable iff (rst)
    !mode_chg |=> $stable(mode_cur));

  // R4: a change inside one bank leaves the status word alone
  a_r4_same_bank_status: assert property (@(posedge clk) disable iff (rst)
    (mode_chg && !sts_wr_en && bank_of(mode_in) == bank_of(mode_cur))
    |=> $stable(sts_rd_data));

  // R7: r8..r12 untouched by changes that do not involve fast-interrupt
  a_r7_hi_untouched: assert property (@(posedge clk) disable iff (rst)
    (mode_chg && !wr_en && !req_fiq && !cur_fiq && rd_in_hi) ##1 $stable(rd_a_idx)
    |-> $stable(rd_a_data));

  // R2: plain write visible on the next cycle
  a_r2_write_visible: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mode_chg) ##1 (rd_a_idx == $past(wr_idx))
    |-> (rd_a_data == $past(wr_data)));

endmodule

bind mode_bank_regfile mbr_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .sts_wr_en   (sts_wr_en),
  .sts_rd_data (sts_rd_data),
  .mode_in     (mode_in),
  .mode_chg    (mode_chg),
  .mode_cur    (mode_cur)
);

// File: tb/mode_bank_regfile_tb_top.sv
`timescale 1ns/1ps
module mode_bank_regfile_tb_top;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sts_wr_data = '0, sts_rd_data;
  logic        wr_en = 1'b0, sts_wr_en = 1'b0, mode_chg = 1'b0;
  logic [4:0]  mode_in = '0, mode_cur;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model
  logic [31:0] m_live [16];
  logic [31:0] m_sp [6], m_lr [6], m_ps [6];
  logic [31:0] m_hi [2][5];
  logic [31:0] m_spsr;
  logic [4:0]  m_mode;

  always #4 clk = ~clk;

  mode_bank_regfile dut_i (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data),
    .mode_in(mode_in), .mode_chg(mode_chg), .mode_cur(mode_cur)
  );

  function automatic int bk(input logic [4:0] m);
    case (m)
      FIQ: return 1;
      IRQ: return 2;
      SVC: return 3;
      ABT: return 4;
      UND: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_live[i] = '0;
    for (int b = 0; b < 6; b++) begin m_sp[b] = '0; m_lr[b] = '0; m_ps[b] = '0; end
    for (int h = 0; h < 2; h++) for (int k = 0; k < 5; k++) m_hi[h][k] = '0;
    m_spsr = '0;
    m_mode = SYS;
  endtask

  // compare every visible register, status word and mode against the model
  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i);
      rd_b_idx = 4'(15 - i);
      #0.2;
      chk(req, rd_a_data, m_live[i]);
      chk(req, rd_b_data, m_live[15-i]);
    end
    chk(req, sts_rd_data, m_spsr);
    chk(req, {27'd0, mode_cur}, {27'd0, m_mode});
  endtask

  // one clock edge with the given stimulus, then model update and full check
  task automatic step(input logic we, input logic [3:0] wi, input logic [31:0] wd,
                      input logic se, input logic [31:0] sd,
                      input logic mc, input logic [4:0] mi, input string req);
    logic [31:0] eff [16];
    logic [31:0] seff;
    int ob, nb, of, nf;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    sts_wr_en = se; sts_wr_data = sd;
    mode_chg = mc; mode_in = mi;
    @(posedge clk);
    for (int i = 0; i < 16; i++) eff[i] = (we && wi == 4'(i)) ? wd : m_live[i];
    seff = se ? sd : m_spsr;
    for (int i = 0; i < 16; i++) m_live[i] = eff[i];
    m_spsr = seff;
    if (mc && mi != m_mode) begin
      ob = bk(m_mode);
      nb = bk(mi);
      if (ob != nb) begin
        if (ob == 1 || nb == 1) begin
          of = (ob == 1) ? 1 : 0;
          nf = (nb == 1) ? 1 : 0;
          for (int k = 0; k < 5; k++) begin
            m_hi[of][k]   = eff[8+k];
            m_live[8+k]   = m_hi[nf][k];
          end
        end
        m_sp[ob] = eff[13]; m_live[13] = m_sp[nb];
        m_lr[ob] = eff[14]; m_live[14] = m_lr[nb];
        m_ps[ob] = seff;    m_spsr     = m_ps[nb];
      end
      m_mode = mi;
    end
    #1;
    wr_en = 1'b0; sts_wr_en = 1'b0; mode_chg = 1'b0;
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    check_all("R1 reset");
  endtask

  task automatic t_plain_writes();
    for (int i = 0; i < 16; i++)
      step(1'b1, 4'(i), 32'hA500_0000 | i, 1'b0, '0, 1'b0, '0, "R2 write");
    step(1'b0, '0, '0, 1'b1, 32'h0BAD_5EED, 1'b0, '0, "R6 status write");
  endtask

  task automatic t_same_bank();
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, SYS, "R4 same mode");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, USR, "R4 sys to usr");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, SYS, "R4 usr to sys");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, 5'b00101, "R3 unknown code");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, 5'b10110, "R3 unknown code 2");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, USR, "R9 back to usr");
  endtask

  task automatic t_bank_walk();
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, IRQ, "R5 enter irq");
    step(1'b1, 4'd13, 32'h1300_0002, 1'b1, 32'h5000_0002, 1'b0, '0, "R5 irq sp");
    step(1'b1, 4'd14, 32'h1400_0002, 1'b0, '0, 1'b0, '0, "R5 irq lr");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, SVC, "R5 irq to svc");
    step(1'b1, 4'd13, 32'h1300_0003, 1'b1, 32'h5000_0003, 1'b0, '0, "R6 svc status");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, ABT, "R5 svc to abt");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, UND, "R5 abt to und");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, IRQ, "R6 und to irq restore");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, SVC, "R6 irq to svc restore");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, SYS, "R5 svc to sys");
    chk("R7 non-fiq shares r9", m_live[9], 32'hA500_0009);
  endtask

  task automatic t_fiq();
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, FIQ, "R7 enter fiq");
    for (int k = 8; k < 13; k++)
      step(1'b1, 4'(k), 32'hF1F0_0000 | k, 1'b0, '0, 1'b0, '0, "R7 fiq hi write");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, IRQ, "R7 fiq to irq");
    step(1'b1, 4'd10, 32'h0101_0A0A, 1'b0, '0, 1'b0, '0, "R7 irq hi write");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, SVC, "R7 irq to svc keeps hi");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, FIQ, "R7 svc to fiq");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, USR, "R7 fiq to usr");
  endtask

  task automatic t_collide();
    step(1'b1, 4'd13, 32'hC011_0013, 1'b1, 32'hC055_0000, 1'b1, FIQ, "R8 sp+status with change");
    step(1'b1, 4'd9, 32'hC011_0009, 1'b0, '0, 1'b1, IRQ, "R8 r9 with leave fiq");
    step(1'b1, 4'd14, 32'hC011_0014, 1'b1, 32'hC055_0002, 1'b1, UND, "R8 lr with change");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, FIQ, "R8 fiq r9 parked");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, IRQ, "R8 irq lr parked");
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, USR, "R8 plain sp parked");
    step(1'b1, 4'd3, 32'hC011_0003, 1'b0, '0, 1'b1, USR, "R8 write with same-mode strobe");
  endtask

  task automatic t_random();
    logic [4:0] codes [8];
    codes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, 5'b01010};
    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)), $urandom,
           $urandom_range(0, 3) == 0, $urandom,
           $urandom_range(0, 2) == 0, codes[$urandom_range(0, 7)],
           "R2-mix R5 R6 R7 R8 random");
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    do_reset();
    t_plain_writes();
    t_same_bank();
    t_bank_walk();
    t_fiq();
    t_collide();
    t_random();
    do_reset();
    finish_run();
  end

endmodule